// File: doc/BRIEF.md
# Single-Accumulator 12-bit Execute Core

This block is the fetch and execute engine of a 12-bit word machine. Its architectural state is one accumulator, a one-bit carry flag and a program counter. Each instruction word has a 3-bit opcode. Six opcodes address memory: bitwise AND, two's-complement add, increment with skip on zero, store-and-clear, subroutine call and jump. One opcode is an operate word that holds several register micro-operations. The remaining opcode does nothing.

The machine has no load instruction. To load a value, software clears the accumulator and adds the memory word to it. The store always leaves the accumulator at zero, so the next add acts as a load.

The core talks to a word-addressed memory through one request/ready port. A transfer completes in any cycle where both request and ready are high. A counter of completed transfers reports execution time. An operate instruction costs one unit and a direct memory-reference instruction costs two.

Top module: `acc12_core`

## Requirements
- R1: While reset is asserted and for two clock cycles after its release, mem_req is low, and the accumulator, carry, PC and transfer counter read zero. The first request is a read of address 0.
- R2: The instruction word is laid out as follows. Bits 11:9 are the opcode. Bit 8 selects indirect addressing. Bit 7 selects the current page (address bits 11:7 of the instruction's own address) instead of page zero. Bits 6:0 are the in-page offset. With indirect addressing, the word read at that address becomes the effective address.
- R3: Opcode 0 ANDs the memory word into the accumulator. The carry is left unchanged.
- R4: Opcode 1 adds the memory word to the accumulator modulo 2^12. A carry out of bit 11 complements the carry flag.
- R5: Opcode 2 writes the memory word plus one back to the same address. When the new value is zero, the next instruction is skipped.
- R6: Opcode 3 writes the accumulator to the effective address and then sets the accumulator to zero. The carry is left unchanged.
- R7: Opcode 4 writes the address of the following instruction to the effective address. Execution continues at the effective address plus one.
- R8: Opcode 5 loads the PC with the effective address. A direct jump costs one transfer and an indirect jump costs two.
- R9: Opcode 6 changes no register and no memory word, apart from the PC advancing by one.
- R10: Opcode 7 with bit 8 clear applies its micro-operations in this order, all in one instruction:
  - First, bit 7 clears the accumulator and bit 6 clears the carry.
  - Second, bit 5 inverts the accumulator and bit 4 inverts the carry.
  - Third, bit 0 increments the accumulator, and a carry out of this increment complements the carry flag.
  - Last, the 13-bit {carry, accumulator} value is rotated. Bit 3 rotates it right and bit 2 rotates it left, and bit 1 makes the rotation two places. When bits 3 and 2 are both set, or bit 1 is set alone, there is no rotation.
- R11: Opcode 7 with bit 8 set changes no register.
- R12: The transfer counter adds exactly one for each completed memory transfer, whatever the number of wait cycles. An operate instruction therefore costs 1 unit, a direct AND, add, store or call costs 2, and an increment-and-skip costs 3. Indirect addressing adds 1 to any of these.
- R13: While mem_req is high and mem_ready is low, the address, write enable and write data hold their values. The accumulator, carry and PC change only at the end of a completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | 12 | Word address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Completes the transfer in the current cycle |
| acc_o | output | 12 | Accumulator |
| carry_o | output | 1 | Carry flag |
| pc_o | output | 12 | Program counter |
| xfer_count_o | output | CNT_W | Completed memory transfers since reset |

## Verification
The assertions check on every cycle that a waiting request holds still and that the transfer counter steps by one only on a completed transfer. They also check that the visible registers change only at a completed transfer, and that the accumulator is zero right after a completed store. Only the bench scenarios can show the result of each opcode:
- carry propagation into the carry flag;
- micro-operation ordering and the corner cases of the rotate bits;
- the skip after an increment to zero;
- the return address written by a call;
- current-page addressing;
- the per-instruction cost, both with a slow memory and with a fast one.

// File: rtl/acc12_pkg.sv
package acc12_pkg;
  localparam int WORD_W = 12;
  localparam int OP_W   = 3;
  localparam int OFS_W  = 7;
  localparam int PAGE_W = WORD_W - OFS_W;
  localparam int IND_BIT = OFS_W + 1;   // indirect flag, also group select for opcode 7
  localparam int CUR_BIT = OFS_W;       // current-page select

  // micro-operation bit positions in the operate word
  localparam int U_CLRA = 7;
  localparam int U_CLRC = 6;
  localparam int U_INVA = 5;
  localparam int U_INVC = 4;
  localparam int U_ROTR = 3;
  localparam int U_ROTL = 2;
  localparam int U_TWO  = 1;
  localparam int U_INCA = 0;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'd0,
    OP_ADD  = 3'd1,
    OP_INCZ = 3'd2,
    OP_STCL = 3'd3,
    OP_CALL = 3'd4,
    OP_JUMP = 3'd5,
    OP_IO   = 3'd6,
    OP_UOP  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DEFER,
    ST_EXEC,
    ST_WRITE
  } st_e;
endpackage

// File: rtl/acc12_rstsync.sv
module acc12_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/acc12_decode.sv
module acc12_decode
  import acc12_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] here,
  output op_e               op,
  output logic              indirect,
  output logic [WORD_W-1:0] ea
);
  logic [PAGE_W-1:0] page;

  always_comb begin
    op       = op_e'(word[WORD_W-1 -: OP_W]);
    indirect = word[IND_BIT];
    page     = word[CUR_BIT] ? here[WORD_W-1 -: PAGE_W] : {PAGE_W{1'b0}};
    ea       = {page, word[OFS_W-1:0]};
  end
endmodule

// File: rtl/acc12_uop.sv
module acc12_uop
  import acc12_pkg::*;
(
  input  logic [WORD_W-1:0] acc_i,
  input  logic              cf_i,
  input  logic [7:0]        uop,
  output logic [WORD_W-1:0] acc_o,
  output logic              cf_o
);
  logic [WORD_W-1:0] a;
  logic              c;
  logic [WORD_W:0]   inc;
  logic              rot_l, rot_r;

  always_comb begin
    a = acc_i;
    c = cf_i;
    if (uop[U_CLRA]) a = '0;
    if (uop[U_CLRC]) c = 1'b0;
    if (uop[U_INVA]) a = ~a;
    if (uop[U_INVC]) c = ~c;
    inc = {1'b0, a} + {{WORD_W{1'b0}}, 1'b1};
    if (uop[U_INCA]) begin
      a = inc[WORD_W-1:0];
      c = c ^ inc[WORD_W];
    end
    rot_l = uop[U_ROTL] & ~uop[U_ROTR];
    rot_r = uop[U_ROTR] & ~uop[U_ROTL];
    for (int i = 0; i < 2; i++) begin
      if (i == 0 || uop[U_TWO]) begin
        if (rot_l)      {c, a} = {a, c};
        else if (rot_r) {c, a} = {a[0], c, a[WORD_W-1:1]};
      end
    end
    acc_o = a;
    cf_o  = c;
  end
endmodule

// File: rtl/acc12_mref.sv
module acc12_mref
  import acc12_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              cf_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              cf_o,
  output logic [WORD_W-1:0] inc_o
);
  logic [WORD_W:0] sum;

  always_comb begin
    sum   = {1'b0, acc_i} + {1'b0, data_i};
    inc_o = data_i + {{(WORD_W-1){1'b0}}, 1'b1};
    acc_o = acc_i;
    cf_o  = cf_i;
    case (op)
      OP_AND: acc_o = acc_i & data_i;
      OP_ADD: begin
        acc_o = sum[WORD_W-1:0];
        cf_o  = cf_i ^ sum[WORD_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc12_core.sv
module acc12_core
  import acc12_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [WORD_W-1:0] acc_o,
  output logic              carry_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [CNT_W-1:0]  xfer_count_o
);
  localparam logic [WORD_W-1:0] ONE_W = {{(WORD_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0]  ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

  logic rst_int_n;
  logic xfer;

  st_e               state_q, st_n;
  op_e               op_q, op_n;
  logic [WORD_W-1:0] acc_q, acc_n, pc_q, pc_n, ea_q, ea_n, wbuf_q, wbuf_n;
  logic              cf_q, cf_n;
  logic [CNT_W-1:0]  cnt_q;

  op_e               d_op;
  logic              d_ind;
  logic [WORD_W-1:0] d_ea;
  logic [WORD_W-1:0] u_acc, m_acc, m_inc;
  logic              u_cf, m_cf;

  acc12_rstsync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_int_n));

  acc12_decode u_dec (.word(mem_rdata), .here(pc_q), .op(d_op), .indirect(d_ind), .ea(d_ea));

  acc12_uop u_uop (.acc_i(acc_q), .cf_i(cf_q), .uop(mem_rdata[7:0]), .acc_o(u_acc), .cf_o(u_cf));

  acc12_mref u_mref (.op(op_q), .acc_i(acc_q), .cf_i(cf_q), .data_i(mem_rdata),
                     .acc_o(m_acc), .cf_o(m_cf), .inc_o(m_inc));

  assign mem_req = rst_int_n;
  assign xfer    = mem_req & mem_ready;

  always_comb begin
    st_n      = state_q;
    op_n      = op_q;
    acc_n     = acc_q;
    cf_n      = cf_q;
    pc_n      = pc_q;
    ea_n      = ea_q;
    wbuf_n    = wbuf_q;
    mem_addr  = ea_q;
    mem_we    = 1'b0;
    mem_wdata = acc_q;
    unique case (state_q)
      ST_FETCH: begin
        mem_addr = pc_q;
        pc_n     = pc_q + ONE_W;
        op_n     = d_op;
        ea_n     = d_ea;
        case (d_op)
          OP_UOP: if (!mem_rdata[IND_BIT]) begin
            acc_n = u_acc;
            cf_n  = u_cf;
          end
          OP_IO: ;
          OP_JUMP: begin
            if (d_ind) st_n = ST_DEFER;
            else       pc_n = d_ea;
          end
          default: st_n = d_ind ? ST_DEFER : ST_EXEC;
        endcase
      end
      ST_DEFER: begin
        if (op_q == OP_JUMP) begin
          pc_n = mem_rdata;
          st_n = ST_FETCH;
        end else begin
          ea_n = mem_rdata;
          st_n = ST_EXEC;
        end
      end
      ST_EXEC: begin
        st_n = ST_FETCH;
        case (op_q)
          OP_AND, OP_ADD: begin
            acc_n = m_acc;
            cf_n  = m_cf;
          end
          OP_INCZ: begin
            wbuf_n = m_inc;
            st_n   = ST_WRITE;
          end
          OP_STCL: begin
            mem_we = 1'b1;
            acc_n  = '0;
          end
          OP_CALL: begin
            mem_we    = 1'b1;
            mem_wdata = pc_q;
            pc_n      = ea_q + ONE_W;
          end
          default: ;
        endcase
      end
      ST_WRITE: begin
        mem_we    = 1'b1;
        mem_wdata = wbuf_q;
        if (wbuf_q == '0) pc_n = pc_q + ONE_W;
        st_n = ST_FETCH;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_FETCH;
      op_q    <= OP_AND;
      acc_q   <= '0;
      cf_q    <= 1'b0;
      pc_q    <= '0;
      ea_q    <= '0;
      wbuf_q  <= '0;
      cnt_q   <= '0;
    end else if (xfer) begin
      state_q <= st_n;
      op_q    <= op_n;
      acc_q   <= acc_n;
      cf_q    <= cf_n;
      pc_q    <= pc_n;
      ea_q    <= ea_n;
      wbuf_q  <= wbuf_n;
      cnt_q   <= cnt_q + ONE_C;
    end
  end

  assign acc_o        = acc_q;
  assign carry_o      = cf_q;
  assign pc_o         = pc_q;
  assign xfer_count_o = cnt_q;
endmodule

// File: rtl/acc12_core_chk.sv
module acc12_core_chk
  import acc12_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic [WORD_W-1:0] acc_o,
  input logic              carry_o,
  input logic [WORD_W-1:0] pc_o,
  input logic [CNT_W-1:0]  xfer_count_o,
  input st_e               state,
  input op_e               op
);
  localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_regs_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ready) |=> ($stable(acc_o) && $stable(carry_o) && $stable(pc_o)));

  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (xfer_count_o == $past(xfer_count_o) + ONE_C));

  assert_count_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ready) |=> $stable(xfer_count_o));

  assert_store_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_we && state == ST_EXEC && op == OP_STCL)
      |=> (acc_o == '0 && carry_o == $past(carry_o)));

  assert_idle_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (xfer_count_o == '0 && acc_o == '0 && pc_o == '0));
endmodule

bind acc12_core acc12_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .acc_o(acc_o), .carry_o(carry_o),
  .pc_o(pc_o), .xfer_count_o(xfer_count_o), .state(state_q), .op(op_q)
);

// File: tb/tb_acc12_core.sv
module tb_acc12_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_we, mem_ready;
  logic [11:0] mem_addr, mem_wdata, mem_rdata;
  logic [11:0] acc_o, pc_o;
  logic        carry_o;
  logic [31:0] xfer_count_o;

  logic [11:0] mem [512];
  logic        slow = 1'b0;
  logic        phase = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  acc12_core dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .acc_o(acc_o), .carry_o(carry_o), .pc_o(pc_o), .xfer_count_o(xfer_count_o)
  );

  assign mem_ready = mem_req & (~slow | phase);
  assign mem_rdata = mem[mem_addr[8:0]];

  always @(posedge clk) begin
    phase <= ~phase;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[8:0]] <= mem_wdata;
  end

  typedef struct packed {
    logic [11:0] a0;
    logic        c0;
    logic [11:0] ins;
    logic [11:0] opnd;
    logic [11:0] ptr;
    logic [11:0] e_acc;
    logic        e_c;
    logic [11:0] e_mem;
    logic [11:0] e_nf;
    logic [7:0]  e_t;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{12'o7070,1'b0,12'o0041,12'o1234,12'o0041,12'o1030,1'b0,12'o1234,12'o0004,8'd6},
    '{12'o0012,1'b0,12'o1041,12'o0005,12'o0041,12'o0017,1'b0,12'o0005,12'o0004,8'd6},
    '{12'o7777,1'b0,12'o1041,12'o0001,12'o0041,12'o0000,1'b1,12'o0001,12'o0004,8'd6},
    '{12'o4000,1'b1,12'o1041,12'o4000,12'o0041,12'o0000,1'b0,12'o4000,12'o0004,8'd6},
    '{12'o0100,1'b0,12'o1442,12'o0023,12'o0041,12'o0123,1'b0,12'o0023,12'o0004,8'd7},
    '{12'o0005,1'b0,12'o2041,12'o0007,12'o0041,12'o0005,1'b0,12'o0010,12'o0004,8'd7},
    '{12'o0000,1'b0,12'o2041,12'o7777,12'o0041,12'o0000,1'b0,12'o0000,12'o0005,8'd7},
    '{12'o4321,1'b1,12'o3041,12'o0000,12'o0041,12'o0000,1'b1,12'o4321,12'o0004,8'd6},
    '{12'o0777,1'b0,12'o3442,12'o0000,12'o0041,12'o0000,1'b0,12'o0777,12'o0004,8'd7},
    '{12'o0006,1'b0,12'o4041,12'o0000,12'o5042,12'o0006,1'b0,12'o0004,12'o0042,8'd6},
    '{12'o0003,1'b0,12'o5060,12'o0000,12'o0041,12'o0003,1'b0,12'o0000,12'o0060,8'd5},
    '{12'o0003,1'b0,12'o5442,12'o0000,12'o0060,12'o0003,1'b0,12'o0000,12'o0060,8'd6},
    '{12'o0011,1'b1,12'o6000,12'o0000,12'o0041,12'o0011,1'b1,12'o0000,12'o0004,8'd5},
    '{12'o0005,1'b0,12'o7041,12'o0000,12'o0041,12'o7773,1'b0,12'o0000,12'o0004,8'd5},
    '{12'o4001,1'b1,12'o7104,12'o0000,12'o0041,12'o0002,1'b1,12'o0000,12'o0004,8'd5},
    '{12'o1234,1'b0,12'o7241,12'o0000,12'o0041,12'o0000,1'b1,12'o0000,12'o0004,8'd5},
    '{12'o0003,1'b0,12'o7012,12'o0000,12'o0041,12'o4000,1'b1,12'o0000,12'o0004,8'd5},
    '{12'o2000,1'b1,12'o7004,12'o0000,12'o0041,12'o4001,1'b0,12'o0000,12'o0004,8'd5},
    '{12'o0017,1'b1,12'o7400,12'o0000,12'o0041,12'o0017,1'b1,12'o0000,12'o0004,8'd5},
    '{12'o0000,1'b0,12'o7060,12'o0000,12'o0041,12'o7777,1'b1,12'o0000,12'o0004,8'd5},
    '{12'o0042,1'b0,12'o7014,12'o0000,12'o0041,12'o0042,1'b0,12'o0000,12'o0004,8'd5},
    '{12'o0042,1'b1,12'o7002,12'o0000,12'o0041,12'o0042,1'b1,12'o0000,12'o0004,8'd5}
  };

  function automatic string tag_of(input logic [11:0] ins);
    case (ins[11:9])
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return ins[8] ? "R11" : "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 12'o0000;
  endtask

  task automatic wait_fetch(input logic [11:0] a, output bit found);
    found = 1'b0;
    for (int i = 0; i < 80 && !found; i++) begin
      @(negedge clk);
      if (mem_req && mem_addr == a) found = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit found;
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "req in reset", int'(mem_req), 0);
    chk("R1", "acc in reset", int'(acc_o), 0);
    chk("R1", "carry in reset", int'(carry_o), 0);
    chk("R1", "pc in reset", int'(pc_o), 0);
    chk("R1", "count in reset", int'(xfer_count_o), 0);
    mem[0] = 12'o5000;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req after release", int'(mem_req), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R1", "first request", int'(mem_req), 1);
    chk("R1", "first address", int'(mem_addr), 0);
    chk("R1", "first is read", int'(mem_we), 0);

    // vector table: prelude clears, loads acc from 040, sets carry, runs one instruction
    for (int v = 0; v < NV; v++) begin
      rst_n = 1'b0;
      @(negedge clk);
      clear_mem();
      mem[0]     = 12'o7300;
      mem[1]     = 12'o1040;
      mem[2]     = VECS[v].c0 ? 12'o7020 : 12'o7000;
      mem[3]     = VECS[v].ins;
      mem[4]     = 12'o5004;
      mem[5]     = 12'o5005;
      mem[9'o40] = VECS[v].a0;
      mem[9'o41] = VECS[v].opnd;
      mem[9'o42] = VECS[v].ptr;
      mem[9'o60] = 12'o5060;
      rst_n = 1'b1;
      wait_fetch(VECS[v].e_nf, found);
      chk(tag_of(VECS[v].ins), "next fetch reached", int'(found), 1);
      chk("R12", "transfer count", int'(xfer_count_o), 4 + int'(VECS[v].e_t) - 4);
      repeat (4) @(negedge clk);
      chk(tag_of(VECS[v].ins), "acc", int'(acc_o), int'(VECS[v].e_acc));
      chk(tag_of(VECS[v].ins), "carry", int'(carry_o), int'(VECS[v].e_c));
      chk(tag_of(VECS[v].ins), "word at 041", int'(mem[9'o41]), int'(VECS[v].e_mem));
    end

    // R2 current-page addressing, R12/R13 with a memory that waits every other cycle
    rst_n = 1'b0;
    @(negedge clk);
    clear_mem();
    slow = 1'b1;
    mem[0]      = 12'o5440;
    mem[9'o40]  = 12'o0200;
    mem[9'o50]  = 12'o0777;
    mem[9'o200] = 12'o1250;
    mem[9'o201] = 12'o5201;
    mem[9'o250] = 12'o0321;
    rst_n = 1'b1;
    wait_fetch(12'o0201, found);
    chk("R2", "current-page flow reached 0201", int'(found), 1);
    chk("R12", "count with wait cycles", int'(xfer_count_o), 4);
    repeat (6) @(negedge clk);
    chk("R2", "current-page operand", int'(acc_o), 12'o0321);
    chk("R13", "carry after slow run", int'(carry_o), 0);
    slow = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule